// File: doc/BRIEF.md
# Dual FIFO Trigger Controller

This block holds the two byte queues of one serial channel: a receive queue filled by a deserializer and drained by the host, and a transmit queue filled by the host and drained by a serializer. Each queue holds 32 bytes by default. A single control register write port sets a queue enable bit, issues per-queue clear requests that cancel themselves, and selects the fill thresholds at which each side asks for service.

The receive request is raised while the receive occupancy is at or above its threshold. The transmit request uses hysteresis. A flag records that the last refill pushed the occupancy above the threshold. While that flag is set, the request is raised once the occupancy drops below the threshold. While it is clear, the request is raised only when the queue is empty. The transmit threshold field is written only when an enhanced-feature enable input is high. The two sides use different threshold tables.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset both counts are 0, both overrun flags are 0, both pop data outputs are 0, the control readback is 0x00, the receive request is 0 and the transmit request is 1 (the transmit queue is empty).
- R2: Each queue returns bytes in push order and holds at most DEPTH bytes. A push is accepted only when the count before that edge is below DEPTH. A push to a full queue is dropped and sets that queue's overrun flag, which stays at 1 until that queue is cleared.
- R3: A pop from an empty queue leaves the count at 0 and leaves the pop data output at the last byte popped. A pop from a non-empty queue presents the head byte on the pop data output after the edge.
- R4: A control write with bit 0 = 1 and bit 1 = 1 clears the receive count, pointers and overrun flag. A write with bit 0 = 1 and bit 2 = 1 does the same for the transmit queue. Pushes and pops in that cycle are discarded, and the other queue is untouched. A write with bit 0 = 0 clears nothing.
- R5: The control readback is {rxSel[7:6], txSel[5:4], 3'b000, enable[0]}. Bits 1 and 2 always read 0.
- R6: Every control write stores bit 0 as the enable bit and bits [7:6] as the receive select. While the enable bit is 0 the receive threshold is 1. While it is 1, selects 00, 01, 10 and 11 give 8, 16, 24 and 28.
- R7: The transmit threshold is 1 until the first control write made with the enhanced enable at 1. After that, transmit selects 00, 01, 10 and 11 give 16, 8, 24 and 30.
- R8: A control write made with the enhanced enable at 0 leaves bits [5:4] of the readback unchanged.
- R9: The receive request is 1 exactly when the receive count is at or above the receive threshold.
- R10: At each clock edge the refill flag is updated from the values before that edge. A transmit clear or a count of 0 clears it. Otherwise a count above the transmit threshold sets it, and otherwise it holds. The transmit request equals (count < threshold) while the flag is 1, and (count == 0) while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control write data |
| enhEn | input | 1 | Enhanced-feature enable, gates the transmit select field |
| cfgRdData | output | 8 | Control register readback |
| rxPush | input | 1 | Push a byte into the receive queue |
| rxPushData | input | WIDTH | Receive byte to push |
| rxPop | input | 1 | Pop a byte from the receive queue |
| rxPopData | output | WIDTH | Last byte popped from the receive queue |
| rxCount | output | CW | Receive occupancy |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| rxIrq | output | 1 | Receive level request |
| txPush | input | 1 | Push a byte into the transmit queue |
| txPushData | input | WIDTH | Transmit byte to push |
| txPop | input | 1 | Pop a byte from the transmit queue |
| txPopData | output | WIDTH | Last byte popped from the transmit queue |
| txCount | output | CW | Transmit occupancy |
| txOverrun | output | 1 | Sticky transmit overrun flag |
| txIrq | output | 1 | Transmit level request |

## Verification
The bench builds the block with the default DEPTH of 32 and WIDTH of 8. The selectable thresholds then lie between 8 and 30, and a full queue is reached in a few dozen cycles. Every threshold crossing, the hysteresis path of the transmit request, overrun on a full queue and reads from an empty queue are all reached in short directed runs. A long random run follows. In that run, control writes that change thresholds or clear a queue land while data traffic is in flight, so clears and threshold changes meet arbitrary queue states.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef struct packed {
    logic rxClear;
    logic txClear;
  } ftcStrobe_t;

  function automatic int unsigned rxLevel(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - depth / 8;
    endcase
  endfunction

  function automatic int unsigned txLevel(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return (3 * depth) / 4;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/ftc_fifo.sv
module ftc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CW-1:0]    count,
  output logic             overrun
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign pushOk = push && (count != CW'(DEPTH));
  assign popOk  = pop && (count != '0);

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !clear) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
      popData <= '0;
    end else if (clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        rdPtr   <= nextPtr(rdPtr);
        popData <= mem[rdPtr];
      end
      count <= count + CW'(pushOk) - CW'(popOk);
      if (push && !pushOk) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ftcStrobe_t            strobe,
  input  logic [1:0]            push,
  input  logic [1:0][WIDTH-1:0] pushData,
  input  logic [1:0]            pop,
  output logic [1:0][WIDTH-1:0] popData,
  output logic [1:0][CW-1:0]    count,
  output logic [1:0]            overrun
);
  // index 0 is the receive queue, index 1 the transmit queue
  logic [1:0] clearVec;
  assign clearVec = {strobe.txClear, strobe.rxClear};

  for (genvar g = 0; g < 2; g++) begin : gQueue
    ftc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (clearVec[g]),
      .push     (push[g]),
      .pushData (pushData[g]),
      .pop      (pop[g]),
      .popData  (popData[g]),
      .count    (count[g]),
      .overrun  (overrun[g])
    );
  end
endmodule

// File: rtl/ftc_ctrl.sv
module ftc_ctrl
  import ftc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [7:0]    cfgWrData,
  input  logic          enhEn,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] txCount,
  output ftcStrobe_t    strobe,
  output logic [7:0]    cfgRdData,
  output logic          rxIrq,
  output logic          txIrq
);
  logic       fifoEn;
  logic [1:0] rxSel, txSel;
  logic       txSelValid;
  logic       txAbove;
  logic [CW-1:0] rxTrig, txTrig;

  // clear requests act only together with the enable bit in the same write
  assign strobe.rxClear = cfgWrEn && cfgWrData[0] && cfgWrData[1];
  assign strobe.txClear = cfgWrEn && cfgWrData[0] && cfgWrData[2];

  assign rxTrig = fifoEn ? CW'(rxLevel(rxSel, DEPTH)) : CW'(1);
  assign txTrig = txSelValid ? CW'(txLevel(txSel, DEPTH)) : CW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn     <= 1'b0;
      rxSel      <= 2'b00;
      txSel      <= 2'b00;
      txSelValid <= 1'b0;
    end else if (cfgWrEn) begin
      fifoEn <= cfgWrData[0];
      rxSel  <= cfgWrData[7:6];
      if (enhEn) begin
        txSel      <= cfgWrData[5:4];
        txSelValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    txAbove <= 1'b0;
    else if (strobe.txClear)      txAbove <= 1'b0;
    else if (txCount == '0)       txAbove <= 1'b0;
    else if (txCount > txTrig)    txAbove <= 1'b1;
  end

  assign rxIrq     = (rxCount >= rxTrig);
  assign txIrq     = txAbove ? (txCount < txTrig) : (txCount == '0);
  assign cfgRdData = {rxSel, txSel, 3'b000, fifoEn};
endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import ftc_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             enhEn,
  output logic [7:0]       cfgRdData,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CW-1:0]    rxCount,
  output logic             rxOverrun,
  output logic             rxIrq,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  output logic [CW-1:0]    txCount,
  output logic             txOverrun,
  output logic             txIrq
);
  ftcStrobe_t strobe;
  logic [1:0][WIDTH-1:0] popDataVec;
  logic [1:0][CW-1:0]    countVec;
  logic [1:0]            overrunVec;

  ftc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .enhEn     (enhEn),
    .rxCount   (countVec[0]),
    .txCount   (countVec[1]),
    .strobe    (strobe),
    .cfgRdData (cfgRdData),
    .rxIrq     (rxIrq),
    .txIrq     (txIrq)
  );

  ftc_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .push     ({txPush, rxPush}),
    .pushData ({txPushData, rxPushData}),
    .pop      ({txPop, rxPop}),
    .popData  (popDataVec),
    .count    (countVec),
    .overrun  (overrunVec)
  );

  assign rxPopData = popDataVec[0];
  assign txPopData = popDataVec[1];
  assign rxCount   = countVec[0];
  assign txCount   = countVec[1];
  assign rxOverrun = overrunVec[0];
  assign txOverrun = overrunVec[1];
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [7:0]       cfgWrData,
  input logic             enhEn,
  input logic [7:0]       cfgRdData,
  input logic             rxPush,
  input logic             rxPop,
  input logic [WIDTH-1:0] rxPopData,
  input logic [CW-1:0]    rxCount,
  input logic             rxIrq,
  input logic             txPush,
  input logic             txPop,
  input logic [CW-1:0]    txCount,
  input logic             txOverrun,
  input logic             txIrq
);
  logic txClr, rxClr;
  assign txClr = cfgWrEn && cfgWrData[0] && cfgWrData[2];
  assign rxClr = cfgWrEn && cfgWrData[0] && cfgWrData[1];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= CW'(DEPTH)) && (txCount <= CW'(DEPTH)));

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CW'(DEPTH) && txPush && !txPop && !txClr) |=> (txCount == CW'(DEPTH) && txOverrun));

  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && rxPop && !rxPush && !rxClr) |=> (rxCount == '0 && $stable(rxPopData)));

  assert_clear_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrData[0] && !rxPush && !rxPop) |=> (rxCount == $past(rxCount)));

  assert_tx_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    txClr |=> (txCount == '0 && !txOverrun));

  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[3:1] == 3'b000);

  assert_tx_sel_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !enhEn) |=> (cfgRdData[5:4] == $past(cfgRdData[5:4])));

  assert_rx_irq_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 |-> !rxIrq) and (rxCount == CW'(DEPTH) |-> rxIrq));

  assert_tx_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == '0) |-> txIrq);
endmodule

bind fifo_trig_ctrl ftc_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .enhEn     (enhEn),
  .cfgRdData (cfgRdData),
  .rxPush    (rxPush),
  .rxPop     (rxPop),
  .rxPopData (rxPopData),
  .rxCount   (rxCount),
  .rxIrq     (rxIrq),
  .txPush    (txPush),
  .txPop     (txPop),
  .txCount   (txCount),
  .txOverrun (txOverrun),
  .txIrq     (txIrq)
);

// File: tb/fifo_trig_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_trig_ctrl_tb;
  localparam int WIDTH = 8;
  localparam int DEPTH = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, enhEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic [WIDTH-1:0] rxPushData = '0, txPushData = '0;
  logic [7:0] cfgRdData;
  logic [WIDTH-1:0] rxPopData, txPopData;
  logic [CW-1:0] rxCount, txCount;
  logic rxOverrun, txOverrun, rxIrq, txIrq;

  always #2.5 clk = ~clk;

  fifo_trig_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .enhEn(enhEn),
    .cfgRdData(cfgRdData), .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxCount(rxCount), .rxOverrun(rxOverrun), .rxIrq(rxIrq),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .txCount(txCount), .txOverrun(txOverrun), .txIrq(txIrq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int rxQ[$], txQ[$];
  int rxLast = 0, txLast = 0;
  bit rxOv = 0, txOv = 0, mEn = 0, mTxValid = 0, mAbove = 0;
  int mRxSel = 0, mTxSel = 0;

  function automatic int rxTrigOf();
    int t[4] = '{DEPTH/4, DEPTH/2, (3*DEPTH)/4, DEPTH - DEPTH/8};
    return mEn ? t[mRxSel] : 1;
  endfunction

  function automatic int txTrigOf();
    int t[4] = '{DEPTH/2, DEPTH/4, (3*DEPTH)/4, DEPTH - 2};
    return mTxValid ? t[mTxSel] : 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int rt = rxTrigOf();
    int tt = txTrigOf();
    check("R2 rxCount", rxCount, rxQ.size());
    check("R2 txCount", txCount, txQ.size());
    check("R2 rxOverrun", rxOverrun, rxOv);
    check("R2 txOverrun", txOverrun, txOv);
    check("R3 rxPopData", rxPopData, rxLast);
    check("R3 txPopData", txPopData, txLast);
    check("R5 cfgRdData", cfgRdData, (mRxSel << 6) | (mTxSel << 4) | mEn);
    check("R9 rxIrq", rxIrq, (rxQ.size() >= rt) ? 1 : 0);
    check("R10 txIrq", txIrq, mAbove ? ((txQ.size() < tt) ? 1 : 0) : ((txQ.size() == 0) ? 1 : 0));
  endtask

  task automatic modelQueue(ref int q[$], ref int last, ref bit ov, input bit clr,
                            input bit push, input int data, input bit pop);
    bit pushOk;
    if (clr) begin
      q.delete();
      ov = 0;
    end else begin
      pushOk = push && (q.size() < DEPTH);
      if (pop && q.size() > 0) last = q.pop_front();
      if (pushOk) q.push_back(data);
      else if (push) ov = 1;
    end
  endtask

  task automatic cyc(bit we, int wd, bit enh, bit rp, int rd, bit rpop, bit tp, int td, bit tpop);
    bit rxClr = we && wd[0] && wd[1];
    bit txClr = we && wd[0] && wd[2];
    int tt = txTrigOf();
    cfgWrEn = we; cfgWrData = wd[7:0]; enhEn = enh;
    rxPush = rp; rxPushData = rd[7:0]; rxPop = rpop;
    txPush = tp; txPushData = td[7:0]; txPop = tpop;
    if (txClr || txQ.size() == 0) mAbove = 0;
    else if (txQ.size() > tt) mAbove = 1;
    modelQueue(rxQ, rxLast, rxOv, rxClr, rp, rd & 8'hFF, rpop);
    modelQueue(txQ, txLast, txOv, txClr, tp, td & 8'hFF, tpop);
    if (we) begin
      mEn = wd[0];
      mRxSel = (wd >> 6) & 3;
      if (enh) begin
        mTxSel = (wd >> 4) & 3;
        mTxValid = 1;
      end
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int wd, bit enh); cyc(1, wd, enh, 0, 0, 0, 0, 0, 0); endtask
  task automatic rxIn(int d); cyc(0, 0, 0, 1, d, 0, 0, 0, 0); endtask
  task automatic rxOut(); cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic txIn(int d); cyc(0, 0, 0, 0, 0, 0, 1, d, 0); endtask
  task automatic txOut(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rxCount", rxCount, 0);
    check("R1 cfgRdData", cfgRdData, 0);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 txIrq", txIrq, 1);
    compareAll();

    // R6 default receive threshold of 1 while disabled
    rxIn(8'h11);
    check("R6 rxIrq at trig 1", rxIrq, 1);
    for (int i = 0; i < 4; i++) rxIn(8'h20 + i);
    rxOut(); rxOut();
    check("R2 order", rxPopData, 8'h20);

    // R7 default transmit threshold of 1
    txIn(1); txIn(2); idle(); txOut();
    check("R7 txIrq count1 trig1", txIrq, 0);
    txOut();
    check("R10 txIrq empty", txIrq, 1);

    // R2 fill transmit queue past full
    for (int i = 0; i < DEPTH + 2; i++) txIn(8'h40 + i);
    check("R2 tx full", txCount, DEPTH);
    check("R2 tx overrun", txOverrun, 1);

    // R4 clear bits ignored without enable bit
    wr(8'h06, 0);
    check("R4 no clear tx", txCount, DEPTH);
    check("R4 no clear rx", rxCount, 3);
    wr(8'h07, 0);
    check("R4 clear tx", txCount, 0);
    check("R4 clear rx", rxCount, 0);
    check("R4 overrun cleared", txOverrun, 0);
    check("R5 bits self clear", cfgRdData, 8'h01);

    // R8 transmit select ignored without enhanced enable
    wr(8'hF1, 0);
    check("R8 readback", cfgRdData, 8'hC1);
    for (int i = 0; i < 27; i++) rxIn(i);
    check("R6 below 28", rxIrq, 0);
    rxIn(27);
    check("R6 at 28", rxIrq, 1);

    // R7 enhanced write: rx select 16, tx select 8, clear tx only
    wr(8'h55, 1);
    check("R4 rx untouched", rxCount, 28);
    check("R7 readback", cfgRdData, 8'h51);
    for (int i = 0; i < 5; i++) txIn(i);
    check("R10 no refill above", txIrq, 0);
    for (int i = 0; i < 4; i++) txOut();
    check("R10 count1 no flag", txIrq, 0);
    txOut();
    check("R10 empty", txIrq, 1);
    for (int i = 0; i < 10; i++) txIn(i);
    idle();
    txOut(); txOut();
    check("R10 at trig 8", txIrq, 0);
    txOut();
    check("R7 below trig 8", txIrq, 1);

    // R3 pop past empty
    while (rxQ.size() > 0) rxOut();
    rxOut(); rxOut();
    check("R3 empty pop data", rxPopData, 27);
    check("R3 empty pop count", rxCount, 0);

    // random traffic with occasional control writes
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 39) == 0);
      cyc(we, $urandom_range(0, 255) | (we && $urandom_range(0, 3) != 0 ? 0 : 0),
          $urandom_range(0, 1),
          $urandom_range(0, 2) != 0, $urandom_range(0, 255), $urandom_range(0, 2) == 0,
          $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule